// File: doc/BRIEF.md
# Data-Processing ALU with Operand Shifter

This block is the arithmetic and logic step of an integer datapath. It accepts a first operand, a candidate second operand from a register, a 12-bit immediate field, shift controls and the current N, Z, C and V flags. The second operand is taken either from an immediate, which is an 8-bit constant rotated right by an even amount, or from the register passed through a barrel shifter. The shift count comes either from a 5-bit field in the instruction or from the low byte of a second register.

A 4-bit opcode picks one of sixteen operations: six add and subtract forms (including carry-chained and reverse-subtract variants), four bitwise operations, two moves and four compares. The compares only produce flags and never request a register write. The other operations write their result and change flags only when the set-flags input is high. Arithmetic operations rewrite all four flags. Logical and move operations take C from the shifter and keep V.

The block registers its result, the write request and the new flags, so each output appears one clock after its inputs are presented. Register file, condition evaluation, multiply and memory access live elsewhere.

Top module: `dpu_top`

## Requirements
- R1: The opcode encodes ADD=4 (a+b), ADC=5 (a+b+C), SUB=2 (a-b), SBC=6 (a-b+C-1), RSB=3 (b-a) and RSC=7 (b-a+C-1). The result is the low 32 bits of the sum, and `result_we` is 1.
- R2: The opcode encodes AND=0 (a&b), EOR=1 (a^b), ORR=12 (a|b), BIC=14 (a&~b), MOV=13 (b) and MVN=15 (~b). `result_we` is 1 for each of them.
- R3: The compare opcodes TST=8 (a&b), TEQ=9 (a^b), CMP=10 (a-b) and CMN=11 (a+b) always update the flags, whatever `set_flags` is, and drive `result_we` to 0.
- R4: For opcodes other than 8 to 11 with `set_flags` low, `flags_out` equals `flags_in`. Flags are packed as {N,Z,C,V} in bits [3:0].
- R5: When an arithmetic operation updates the flags, N is bit 31 of the sum and Z is set when the sum is zero. C is the carry out of bit 31; for subtract forms this is the inverse of the borrow. V is set on signed overflow.
- R6: When a logical or move operation updates the flags, N and Z follow the result, C takes the second-operand carry, and V keeps its incoming value.
- R7: With `imm_sel`=1 the second operand is `imm_field[7:0]` rotated right by 2*`imm_field[11:8]`. Its carry is bit 31 of that value when the rotate count is non-zero, and the incoming C otherwise.
- R8: `shift_kind` encodes LSL=0, LSR=1, ASR=2 and ROR=3. For an amount from 1 to 31, logical shifts fill with zeros, ASR fills with the sign, ROR rotates, and the carry is the last bit shifted out.
- R9: `shift_kind`=4 (rotate right extended) shifts right by one place, ignoring the amount. The incoming C goes into bit 31 and bit 0 becomes the carry.
- R10: A shift amount of 0 from either source, and the unused `shift_kind` values 5 to 7, pass the register unchanged with the incoming C as carry.
- R11: With `amt_sel`=1 the amount is `amt_reg` (0 to 255). At 32, LSL gives 0 with carry bit 0 and LSR gives 0 with carry bit 31. Above 32 both give 0 with carry 0. ASR at 32 or more fills every bit and the carry with the sign. ROR uses the amount modulo 32; a non-zero multiple of 32 keeps the value and takes bit 31 as carry.
- R12: While `rst_n` is low, `result`, `result_we` and `flags_out` are 0. Otherwise each output reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | 32 | First operand |
| b_reg | input | 32 | Register candidate for the second operand |
| imm_sel | input | 1 | 1 selects the rotated immediate as second operand |
| imm_field | input | 12 | Rotate count [11:8] and 8-bit constant [7:0] |
| shift_kind | input | 3 | Shift type applied to `b_reg` |
| amt_sel | input | 1 | 1 takes the shift amount from `amt_reg` |
| amt_imm | input | 5 | Instruction-field shift amount |
| amt_reg | input | 8 | Low byte of the amount register |
| opcode | input | 4 | Operation select |
| set_flags | input | 1 | Flag update request for non-compare operations |
| flags_in | input | 4 | Incoming {N,Z,C,V} |
| result | output | 32 | Registered result |
| result_we | output | 1 | Registered write request for `result` |
| flags_out | output | 4 | Registered {N,Z,C,V} |

## Verification
Every result, write request and flag is due exactly one rising edge after its inputs are presented. The bench therefore changes inputs on a falling edge and compares all outputs at the following falling edge, with the single capturing edge in between. One dedicated check samples just before that edge to confirm the previous vector's result is still held. Expected values come from a step-by-step shift model and from wide signed and unsigned arithmetic. The sweeps cover every opcode against boundary operands and all sixteen flag inputs, every shift kind at amounts 0 to 40 plus 64 and 255 from both amount sources, and every immediate rotate count.

// File: rtl/dpu_pkg.sv
package dpu_pkg;
  localparam int DW     = 32;
  localparam int IMM_W  = 12;
  localparam int AMT_W  = 8;
  localparam int SAMT_W = $clog2(DW);
  localparam int ROT_W  = IMM_W - 8;
  localparam int FL_W   = 4;

  // second-operand shift kinds
  localparam logic [2:0] SH_LSL = 3'd0;
  localparam logic [2:0] SH_LSR = 3'd1;
  localparam logic [2:0] SH_ASR = 3'd2;
  localparam logic [2:0] SH_ROR = 3'd3;
  localparam logic [2:0] SH_RRX = 3'd4;

  // operation codes
  localparam logic [3:0] OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3;
  localparam logic [3:0] OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7;
  localparam logic [3:0] OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB;
  localparam logic [3:0] OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  function automatic logic is_compare(input logic [3:0] op);
    return op[3:2] == 2'b10;
  endfunction

  function automatic logic is_arith(input logic [3:0] op);
    return (op inside {OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC, OP_CMP, OP_CMN});
  endfunction

  // returns {carry, value}
  function automatic logic [DW:0] shift_apply(input logic [2:0] kind, input logic [DW-1:0] v,
                                              input logic [AMT_W-1:0] amt, input logic cin);
    logic [DW:0]     t;
    logic [2*DW-1:0] rr;
    logic [DW:0]     o;
    o = {cin, v};
    if (kind == SH_RRX) begin
      o = {v[0], cin, v[DW-1:1]};
    end else if (amt != '0) begin
      unique case (kind)
        SH_LSL: begin t = {1'b0, v} << amt; o = t; end
        SH_LSR: begin t = {v, 1'b0} >> amt; o = {t[0], t[DW:1]}; end
        SH_ASR: begin t = $signed({v, 1'b0}) >>> amt; o = {t[0], t[DW:1]}; end
        SH_ROR: begin rr = {v, v} >> amt[SAMT_W-1:0]; o = {rr[DW-1], rr[DW-1:0]}; end
        default: o = {cin, v};
      endcase
    end
    return o;
  endfunction

  // returns {carry, value}
  function automatic logic [DW:0] imm_expand(input logic [IMM_W-1:0] f, input logic cin);
    logic [DW-1:0]   base;
    logic [2*DW-1:0] rr;
    logic [ROT_W-1:0] rot;
    rot  = f[IMM_W-1:8];
    base = {{(DW-8){1'b0}}, f[7:0]};
    rr   = {base, base} >> {rot, 1'b0};
    return {(rot == '0) ? cin : rr[DW-1], rr[DW-1:0]};
  endfunction
endpackage

// File: rtl/dpu_operand_b.sv
module dpu_operand_b
  import dpu_pkg::*;
(
  input  logic             imm_sel,
  input  logic [IMM_W-1:0] imm_field,
  input  logic [DW-1:0]    b_reg,
  input  logic [2:0]       shift_kind,
  input  logic             amt_sel,
  input  logic [SAMT_W-1:0] amt_imm,
  input  logic [AMT_W-1:0] amt_reg,
  input  logic             c_in,
  output logic [DW-1:0]    b_val,
  output logic             b_carry
);
  logic [AMT_W-1:0] amt_w;
  logic [DW:0]      imm_w;
  logic [DW:0]      shf_w;

  assign amt_w = amt_sel ? amt_reg : {{(AMT_W-SAMT_W){1'b0}}, amt_imm};
  assign imm_w = imm_expand(imm_field, c_in);
  assign shf_w = shift_apply(shift_kind, b_reg, amt_w, c_in);
  assign {b_carry, b_val} = imm_sel ? imm_w : shf_w;

  always_comb begin
    if (!$isunknown({imm_sel, shift_kind, amt_sel, amt_reg, b_val, b_carry})) begin
      // R11: logical shifts by more than the word width clear value and carry
      if (!imm_sel && amt_sel && amt_reg > AMT_W'(DW) &&
          (shift_kind == SH_LSL || shift_kind == SH_LSR))
        a_r11_wide_logical_zero: assert (b_val == '0 && !b_carry);
    end
    if (!$isunknown({imm_sel, imm_field, b_val, b_carry})) begin
      // R7: a non-zero rotate count reports bit 31 of the immediate as carry
      if (imm_sel && imm_field[IMM_W-1:8] != '0)
        a_r7_imm_carry_msb: assert (b_carry == b_val[DW-1]);
    end
  end
endmodule

// File: rtl/dpu_adder.sv
module dpu_adder
  import dpu_pkg::*;
(
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic          ci,
  output logic [DW-1:0] sum,
  output logic          co,
  output logic          ovf
);
  assign {co, sum} = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, ci};
  assign ovf = (x[DW-1] == y[DW-1]) && (sum[DW-1] != x[DW-1]);

  always_comb begin
    if (!$isunknown({x, y, ovf}))
      if (x[DW-1] != y[DW-1])
        a_r5_no_ovf_mixed_signs: assert (!ovf);
  end
endmodule

// File: rtl/dpu_alu_core.sv
module dpu_alu_core
  import dpu_pkg::*;
(
  input  logic [3:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          b_carry,
  input  nzcv_t         fl_in,
  input  logic          set_flags,
  output logic [DW-1:0] res,
  output logic          we,
  output nzcv_t         fl_out
);
  logic [DW-1:0] ax, ay, sum_w, lres;
  logic          aci, co_w, ovf_w;
  logic          arith_w, upd_w;

  // one adder serves every add, subtract and reverse-subtract form
  always_comb begin
    ax = a; ay = b; aci = 1'b0;
    unique case (op)
      OP_ADC:         aci = fl_in.c;
      OP_SUB, OP_CMP: begin ay = ~b; aci = 1'b1; end
      OP_SBC:         begin ay = ~b; aci = fl_in.c; end
      OP_RSB:         begin ax = b; ay = ~a; aci = 1'b1; end
      OP_RSC:         begin ax = b; ay = ~a; aci = fl_in.c; end
      default: ;
    endcase
  end

  dpu_adder u_add (.x(ax), .y(ay), .ci(aci), .sum(sum_w), .co(co_w), .ovf(ovf_w));

  always_comb begin
    unique case (op)
      OP_AND, OP_TST: lres = a & b;
      OP_EOR, OP_TEQ: lres = a ^ b;
      OP_ORR:         lres = a | b;
      OP_MOV:         lres = b;
      OP_BIC:         lres = a & ~b;
      OP_MVN:         lres = ~b;
      default:        lres = '0;
    endcase
  end

  assign arith_w = is_arith(op);
  assign upd_w   = is_compare(op) || set_flags;
  assign res     = arith_w ? sum_w : lres;
  assign we      = !is_compare(op);

  always_comb begin
    fl_out = fl_in;
    if (upd_w) begin
      fl_out.n = res[DW-1];
      fl_out.z = (res == '0);
      fl_out.c = arith_w ? co_w : b_carry;
      fl_out.v = arith_w ? ovf_w : fl_in.v;
    end
  end
endmodule

// File: rtl/dpu_top.sv
module dpu_top
  import dpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     op_a,
  input  logic [DW-1:0]     b_reg,
  input  logic              imm_sel,
  input  logic [IMM_W-1:0]  imm_field,
  input  logic [2:0]        shift_kind,
  input  logic              amt_sel,
  input  logic [SAMT_W-1:0] amt_imm,
  input  logic [AMT_W-1:0]  amt_reg,
  input  logic [3:0]        opcode,
  input  logic              set_flags,
  input  logic [FL_W-1:0]   flags_in,
  output logic [DW-1:0]     result,
  output logic              result_we,
  output logic [FL_W-1:0]   flags_out
);
  logic [DW-1:0] b_val_w, res_w;
  logic          b_carry_w, we_w;
  nzcv_t         fl_next_w;
  logic          is_cmp_w, is_logic_w, upd_w;

  dpu_operand_b u_opb (
    .imm_sel(imm_sel), .imm_field(imm_field), .b_reg(b_reg), .shift_kind(shift_kind),
    .amt_sel(amt_sel), .amt_imm(amt_imm), .amt_reg(amt_reg), .c_in(flags_in[1]),
    .b_val(b_val_w), .b_carry(b_carry_w)
  );

  dpu_alu_core u_core (
    .op(opcode), .a(op_a), .b(b_val_w), .b_carry(b_carry_w), .fl_in(nzcv_t'(flags_in)),
    .set_flags(set_flags), .res(res_w), .we(we_w), .fl_out(fl_next_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result    <= '0;
      result_we <= 1'b0;
      flags_out <= '0;
    end else begin
      result    <= res_w;
      result_we <= we_w;
      flags_out <= fl_next_w;
    end
  end

  // named decode events for the checks below
  assign is_cmp_w   = is_compare(opcode);
  assign is_logic_w = !is_arith(opcode);
  assign upd_w      = is_cmp_w || set_flags;

  a_r3_compare_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmp_w |=> !result_we);
  a_r1_write_requested: assert property (@(posedge clk) disable iff (!rst_n)
    !is_cmp_w |=> result_we);
  a_r4_flags_held: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_w |=> flags_out == $past(flags_in));
  a_r5_nz_follow_result: assert property (@(posedge clk) disable iff (!rst_n)
    upd_w |=> (flags_out[3] == result[DW-1]) && (flags_out[2] == (result == '0)));
  a_r6_logic_keeps_v: assert property (@(posedge clk) disable iff (!rst_n)
    is_logic_w |=> flags_out[0] == $past(flags_in[0]));
endmodule

// File: tb/tb_dpu_top.sv
module tb_dpu_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0, b_reg = '0;
  logic        imm_sel = 1'b0;
  logic [11:0] imm_field = '0;
  logic [2:0]  shift_kind = '0;
  logic        amt_sel = 1'b0;
  logic [4:0]  amt_imm = '0;
  logic [7:0]  amt_reg = '0;
  logic [3:0]  opcode = '0;
  logic        set_flags = 1'b0;
  logic [3:0]  flags_in = '0;
  logic [31:0] result;
  logic        result_we;
  logic [3:0]  flags_out;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;   // 250 MHz

  dpu_top dut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .b_reg(b_reg), .imm_sel(imm_sel),
    .imm_field(imm_field), .shift_kind(shift_kind), .amt_sel(amt_sel), .amt_imm(amt_imm),
    .amt_reg(amt_reg), .opcode(opcode), .set_flags(set_flags), .flags_in(flags_in),
    .result(result), .result_we(result_we), .flags_out(flags_out)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // shift model: one place at a time
  function automatic logic [32:0] m_shift(logic [2:0] kind, logic [31:0] v, int amt, logic cin);
    logic c = cin;
    if (kind == 3'd4) begin
      c = v[0]; v = {cin, v[31:1]};
    end else if (kind < 3'd4) begin
      for (int i = 0; i < amt; i++) begin
        case (kind)
          3'd0: begin c = v[31]; v = v << 1; end
          3'd1: begin c = v[0];  v = v >> 1; end
          3'd2: begin c = v[0];  v = {v[31], v[31:1]}; end
          default: begin c = v[0]; v = {v[0], v[31:1]}; end
        endcase
      end
    end
    return {c, v};
  endfunction

  function automatic logic [32:0] m_imm(logic [11:0] f, logic cin);
    logic [31:0] v = {24'd0, f[7:0]};
    for (int i = 0; i < 2 * int'(f[11:8]); i++) v = {v[0], v[31:1]};
    return {(f[11:8] != 0) ? v[31] : cin, v};
  endfunction

  task automatic m_alu(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic bc, input logic [3:0] fin, input logic sf,
                       output logic [31:0] res, output logic we, output logic [3:0] fl);
    longint ua = a, ub = b, sa = longint'($signed(a)), sb = longint'($signed(b));
    longint u = 0, s = 0;
    longint ci = fin[1] ? 1 : 0;
    bit arith = 1, addk = 1, cmpk = (op >= 8 && op <= 11);
    logic c, v;
    case (op)
      4'd4, 4'd11: begin u = ua + ub; s = sa + sb; end
      4'd5:        begin u = ua + ub + ci; s = sa + sb + ci; end
      4'd2, 4'd10: begin addk = 0; u = ua - ub; s = sa - sb; end
      4'd6:        begin addk = 0; u = ua - ub - 1 + ci; s = sa - sb - 1 + ci; end
      4'd3:        begin addk = 0; u = ub - ua; s = sb - sa; end
      4'd7:        begin addk = 0; u = ub - ua - 1 + ci; s = sb - sa - 1 + ci; end
      default: arith = 0;
    endcase
    case (op)
      4'd0, 4'd8: res = a & b;
      4'd1, 4'd9: res = a ^ b;
      4'd12: res = a | b;
      4'd13: res = b;
      4'd14: res = a & ~b;
      4'd15: res = ~b;
      default: res = u[31:0];
    endcase
    c = arith ? (addk ? (u > 64'sh0FFFFFFFF) : (u >= 0)) : bc;
    v = arith ? (s > 64'sd2147483647 || s < -64'sd2147483648) : fin[0];
    we = !cmpk;
    fl = (cmpk || sf) ? {res[31], res == 0, c, v} : fin;
  endtask

  // drive on a falling edge, check at the next falling edge (one capture edge between)
  task automatic run_vec(string tag);
    logic [32:0] bm;
    logic [31:0] er;
    logic ew;
    logic [3:0] ef;
    int amt = amt_sel ? int'(amt_reg) : int'(amt_imm);
    bm = imm_sel ? m_imm(imm_field, flags_in[1]) : m_shift(shift_kind, b_reg, amt, flags_in[1]);
    m_alu(opcode, op_a, bm[31:0], bm[32], flags_in, set_flags, er, ew, ef);
    @(negedge clk);
    chk(tag, "result", result, er);
    chk(tag, "we", {31'd0, result_we}, {31'd0, ew});
    chk(tag, "flags", {28'd0, flags_out}, {28'd0, ef});
  endtask

  localparam logic [31:0] PAT [6] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 32'h12345678};
  localparam logic [31:0] SVAL [4] = '{32'h80000001, 32'h7FFFFFFE, 32'hF0F0A5A5, 32'h00000000};
  localparam logic [7:0]  IV [8] = '{8'h00, 8'h01, 8'h80, 8'hFF, 8'h3C, 8'hA5, 8'h02, 8'h40};

  initial begin
    // R12: reset state with busy inputs
    op_a = 32'hDEADBEEF; b_reg = 32'h1; opcode = 4'd4; flags_in = 4'hF; set_flags = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12", "reset result", result, 32'h0);
    chk("R12", "reset we", {31'd0, result_we}, 32'h0);
    chk("R12", "reset flags", {28'd0, flags_out}, 32'h0);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R5 R6: every opcode, boundary operands, all flag inputs
    for (int op = 0; op < 16; op++)
      for (int sf = 0; sf < 2; sf++)
        for (int ia = 0; ia < 6; ia++)
          for (int ib = 0; ib < 6; ib++)
            for (int f = 0; f < 16; f++) begin
              string tg;
              bit cmp = (op >= 8 && op <= 11);
              bit ar = (op inside {2, 3, 4, 5, 6, 7, 10, 11});
              tg = cmp ? "R3" : (sf == 0 ? "R4" : (ar ? "R1 R5" : "R2 R6"));
              opcode = 4'(op); set_flags = sf[0]; op_a = PAT[ia]; b_reg = PAT[ib];
              flags_in = 4'(f); imm_sel = 0; shift_kind = 3'd0; amt_sel = 0; amt_imm = 0;
              run_vec(tg);
            end

    // R8 R9 R10 R11: shift kinds and amounts from both sources, seen through MOV/MVN
    for (int k = 0; k < 8; k++)
      for (int am = 0; am < 43; am++)
        for (int vi = 0; vi < 4; vi++)
          for (int src = 0; src < 2; src++)
            for (int ci = 0; ci < 2; ci++)
              for (int mv = 0; mv < 2; mv++) begin
                string tg;
                int amt = (am == 41) ? 64 : (am == 42) ? 255 : am;
                if (src == 0 && amt > 31) continue;
                tg = (k == 4) ? "R9" : (k > 4 || amt == 0) ? "R10" : (amt >= 32) ? "R11" : "R8";
                opcode = mv ? 4'd15 : 4'd13; set_flags = 1; op_a = 32'h0;
                b_reg = SVAL[vi]; imm_sel = 0; shift_kind = 3'(k); amt_sel = src[0];
                amt_imm = 5'(amt); amt_reg = 8'(amt); flags_in = ci ? 4'b0011 : 4'b0000;
                run_vec(tg);
              end

    // R7: every rotate count
    for (int r = 0; r < 16; r++)
      for (int iv = 0; iv < 8; iv++)
        for (int ci = 0; ci < 2; ci++) begin
          opcode = 4'd13; set_flags = 1; imm_sel = 1;
          imm_field = {4'(r), IV[iv]}; flags_in = ci ? 4'b0010 : 4'b0101;
          run_vec("R7");
        end

    // R6: shifter carry reaches C through a compare-class logical op
    opcode = 4'd8; set_flags = 0; imm_sel = 0; op_a = 32'hFFFFFFFF; b_reg = 32'h00000003;
    shift_kind = 3'd1; amt_sel = 0; amt_imm = 5'd1; flags_in = 4'b0001;
    run_vec("R6");

    // R12: output holds the previous vector until the capturing edge
    opcode = 4'd13; imm_sel = 0; shift_kind = 3'd0; amt_imm = 0; b_reg = 32'hCAFE0001;
    set_flags = 0; flags_in = 4'h0;
    run_vec("R12");
    b_reg = 32'h00000077;
    #1;
    chk("R12", "held before edge", result, 32'hCAFE0001);
    @(negedge clk);
    chk("R12", "after edge", result, 32'h00000077);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule